// File: doc/BRIEF.md
# Dynamic Memory Row Refresh Scheduler

This block keeps a dynamic memory array alive. Every row must be read, sense-amplified and written back before its cells lose their charge. The scheduler spreads one refresh request per row evenly across half of the cell hold time. Any single row is therefore revisited twice per hold period, which gives a twofold safety margin. A free-running cycle counter turns the hold-time parameter, given in clock cycles, into a per-row spacing. A row counter walks the array and wraps back to row zero after the last row.

Each refresh runs three phases in a fixed order: read, amplify, rewrite. Each phase lasts a parameterised number of cycles. The word line of the row being refreshed is the only one raised while the sequence runs. All word lines are low when the controller is idle, so the cells hold their charge. A single user access port shares the array. A refresh that is due or running takes priority. The port sees a busy flag and waits for its grant. A configuration flag, derived purely from the parameters, reports when the rows cannot all be refreshed inside the half-hold-time budget.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and after it is released, all word lines, phase strobes, `acc_act`, `acc_gnt` and `acc_busy` are 0, and `ref_row` is 0.
- R2: With no access traffic, successive refresh sequences start exactly INTERVAL = (HOLD_CYC/2)/ROWS cycles apart (minimum 1).
- R3: A refresh asserts `rd_ph`, then `amp_ph`, then `wr_ph`. Each strobe is high for exactly PH_CYC cycles, the next follows in the cycle after, and at most one of the three strobes and `acc_act` is high at a time.
- R4: During all three refresh phases, `wl` is one-hot with bit `ref_row` set, where bit i of `wl` drives row i.
- R5: Rows are refreshed in the order 0, 1, …, ROWS-1, 0, … (`ref_row` advances by one after each rewrite phase and wraps to 0). One full pass takes ROWS×INTERVAL cycles, which does not exceed HOLD_CYC/2.
- R6: Whenever no refresh phase and no access is active, `wl` is all zero.
- R7: `acc_busy` is high whenever a refresh is running or due. `acc_gnt` never rises while `acc_busy` is high. When an access request and a due refresh meet in the same idle cycle, the refresh starts in the next cycle and the access waits.
- R8: A granted access (`acc_gnt` high for one cycle while `acc_req` is held) is followed by `acc_act` high for exactly ACC_CYC cycles. During those cycles `wl` is one-hot on the row that was presented on `acc_row` at the grant.
- R9: `cfg_err` is 1 exactly when ROWS×3×PH_CYC exceeds HOLD_CYC/2, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_req | input | 1 | User access request, held until granted |
| acc_row | input | ROW_W | Row for the user access |
| acc_gnt | output | 1 | One-cycle pulse: request accepted this cycle |
| acc_busy | output | 1 | Refresh running or due; access must wait |
| acc_act | output | 1 | User access in progress |
| wl | output | ROWS | One-hot word line drive, all zero when idle |
| rd_ph | output | 1 | Refresh read phase strobe |
| amp_ph | output | 1 | Refresh amplify phase strobe |
| wr_ph | output | 1 | Refresh rewrite phase strobe |
| ref_row | output | ROW_W | Row currently or next to be refreshed |
| cfg_err | output | 1 | Array cannot be refreshed inside half the hold time |

## Verification
The hardest case to reach is an access request arriving in the very cycle a refresh becomes due, because the due instant is internal. The stimulus waits for a refresh to start, counts INTERVAL-1 cycles forward to the next due cycle, raises the request there, and expects busy with no grant, followed by a read phase. The wrap to row zero and the full-pass length are reached by letting the scheduler run through two passes. The configuration flag is covered by a second instance whose hold time is too short for its row count.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_AMP   = 3'd2,
    ST_WRITE = 3'd3,
    ST_ACC   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int INTERVAL = 78
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = (row_q == LAST) ? '0 : row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row_q <= '0;
    else if (adv) row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PH_CYC  = 2,
  parameter int ACC_CYC = 4,
  parameter int ROW_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             acc_req,
  input  logic [ROW_W-1:0] acc_row,
  output logic             ref_done,
  output logic             acc_gnt,
  output logic             acc_busy,
  output logic             rd_ph,
  output logic             amp_ph,
  output logic             wr_ph,
  output logic             acc_act,
  output logic [ROW_W-1:0] acc_row_q
);
  localparam int MAXC  = (PH_CYC > ACC_CYC) ? PH_CYC : ACC_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PH_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] arow_q;
  logic             arow_en;
  logic             due;
  logic             start_ref;

  always_comb begin
    due       = pend_q | tick;
    start_ref = (state_q == ST_IDLE) && due;
    pend_d    = due && !start_ref;
    state_d   = state_q;
    cnt_d     = cnt_q;
    arow_en   = 1'b0;
    ref_done  = 1'b0;
    acc_gnt   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (due) begin
          state_d = ST_READ;
        end else if (acc_req) begin
          state_d = ST_ACC;
          arow_en = 1'b1;
          acc_gnt = 1'b1;
        end
      end
      ST_READ: begin
        if (cnt_q == PH_LAST) begin
          state_d = ST_AMP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_AMP: begin
        if (cnt_q == PH_LAST) begin
          state_d = ST_WRITE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WRITE: begin
        if (cnt_q == PH_LAST) begin
          state_d  = ST_IDLE;
          cnt_d    = '0;
          ref_done = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ACC: begin
        if (cnt_q == ACC_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arow_q <= '0;
    else if (arow_en) arow_q <= acc_row;
  end

  assign rd_ph     = (state_q == ST_READ);
  assign amp_ph    = (state_q == ST_AMP);
  assign wr_ph     = (state_q == ST_WRITE);
  assign acc_act   = (state_q == ST_ACC);
  assign acc_busy  = rd_ph | amp_ph | wr_ph | due;
  assign acc_row_q = arow_q;
endmodule

// File: rtl/rfsh_wl_dec.sv
module rfsh_wl_dec #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4
) (
  input  logic             en,
  input  logic [ROW_W-1:0] idx,
  output logic [ROWS-1:0]  wl
);
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign wl[g] = en && (idx == ROW_W'(g));
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int HOLD_CYC = 2500,
  parameter int ROWS     = 16,
  parameter int PH_CYC   = 2,
  parameter int ACC_CYC  = 4,
  parameter int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_req,
  input  logic [ROW_W-1:0] acc_row,
  output logic             acc_gnt,
  output logic             acc_busy,
  output logic             acc_act,
  output logic [ROWS-1:0]  wl,
  output logic             rd_ph,
  output logic             amp_ph,
  output logic             wr_ph,
  output logic [ROW_W-1:0] ref_row,
  output logic             cfg_err
);
  localparam int HALF_CYC = HOLD_CYC / 2;
  localparam int OP_CYC   = 3 * PH_CYC;
  localparam int RAW_INT  = HALF_CYC / ROWS;
  localparam int INTERVAL = (RAW_INT < 1) ? 1 : RAW_INT;
  localparam logic CFG_BAD = (ROWS * OP_CYC) > HALF_CYC;

  logic             rst_n_s;
  logic             tick;
  logic             ref_done;
  logic [ROW_W-1:0] arow_q;
  logic [ROW_W-1:0] sel_row;
  logic             wl_en;

  rfsh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rfsh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_s),
    .tick  (tick)
  );

  rfsh_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (ref_done),
    .row   (ref_row)
  );

  rfsh_seq #(.PH_CYC(PH_CYC), .ACC_CYC(ACC_CYC), .ROW_W(ROW_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick      (tick),
    .acc_req   (acc_req),
    .acc_row   (acc_row),
    .ref_done  (ref_done),
    .acc_gnt   (acc_gnt),
    .acc_busy  (acc_busy),
    .rd_ph     (rd_ph),
    .amp_ph    (amp_ph),
    .wr_ph     (wr_ph),
    .acc_act   (acc_act),
    .acc_row_q (arow_q)
  );

  assign sel_row = acc_act ? arow_q : ref_row;
  assign wl_en   = rd_ph | amp_ph | wr_ph | acc_act;

  rfsh_wl_dec #(.ROWS(ROWS), .ROW_W(ROW_W)) u_dec (
    .en  (wl_en),
    .idx (sel_row),
    .wl  (wl)
  );

  assign cfg_err = CFG_BAD;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_gnt,
  input logic             acc_busy,
  input logic             acc_act,
  input logic [ROWS-1:0]  wl,
  input logic             rd_ph,
  input logic             amp_ph,
  input logic             wr_ph,
  input logic [ROW_W-1:0] ref_row
);
  logic in_ref;
  assign in_ref = rd_ph | amp_ph | wr_ph;

  // R3
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ph, amp_ph, wr_ph, acc_act}));

  // R3
  rd_then_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_ph) |-> amp_ph);

  // R3
  amp_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amp_ph) |-> wr_ph);

  // R3
  wr_after_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ph) |-> $past(amp_ph));

  // R4
  ref_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ref |-> (wl == (ROWS'(1) << ref_row)));

  // R6
  idle_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ref || acc_act) |-> (wl == '0));

  // R5
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_ph) |-> (ref_row == (($past(ref_row) == ROW_W'(ROWS - 1)) ?
                                  '0 : $past(ref_row) + ROW_W'(1))));

  // R7
  gnt_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> !acc_busy);

  // R7
  ref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ref |-> acc_busy);

  // R8
  acc_wl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_act && $past(acc_act)) |-> $stable(wl));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_gnt  (acc_gnt),
  .acc_busy (acc_busy),
  .acc_act  (acc_act),
  .wl       (wl),
  .rd_ph    (rd_ph),
  .amp_ph   (amp_ph),
  .wr_ph    (wr_ph),
  .ref_row  (ref_row)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int HOLD     = 2500;
  localparam int ROWS     = 16;
  localparam int PH       = 2;
  localparam int ACC      = 4;
  localparam int ROW_W    = 4;
  localparam int INTERVAL = (HOLD / 2) / ROWS;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_req;
  logic [ROW_W-1:0] acc_row;
  logic             acc_gnt, acc_busy, acc_act;
  logic [ROWS-1:0]  wl;
  logic             rd_ph, amp_ph, wr_ph;
  logic [ROW_W-1:0] ref_row;
  logic             cfg_err;

  logic             b_gnt, b_busy, b_act, b_rd, b_amp, b_wr, b_err;
  logic [ROWS-1:0]  b_wl;
  logic [ROW_W-1:0] b_row;

  always #10 clk = ~clk;

  dram_refresh_sched #(.HOLD_CYC(HOLD), .ROWS(ROWS), .PH_CYC(PH), .ACC_CYC(ACC)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_row(acc_row),
    .acc_gnt(acc_gnt), .acc_busy(acc_busy), .acc_act(acc_act), .wl(wl),
    .rd_ph(rd_ph), .amp_ph(amp_ph), .wr_ph(wr_ph), .ref_row(ref_row),
    .cfg_err(cfg_err)
  );

  dram_refresh_sched #(.HOLD_CYC(100), .ROWS(ROWS), .PH_CYC(PH), .ACC_CYC(ACC)) u_bad (
    .clk(clk), .rst_n(rst_n), .acc_req(1'b0), .acc_row('0),
    .acc_gnt(b_gnt), .acc_busy(b_busy), .acc_act(b_act), .wl(b_wl),
    .rd_ph(b_rd), .amp_ph(b_amp), .wr_ph(b_wr), .ref_row(b_row),
    .cfg_err(b_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_on = 0;
  bit done   = 0;
  int exp_ref[$];
  int exp_acc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops expected rows and compares as the design produces them
  bit p_rd = 0, p_amp = 0, p_wr = 0, p_acc = 0, acc_seen = 0;
  int n_rd = 0, n_amp = 0, n_wr = 0, n_acc = 0;
  int last_start = -1, last_zero = -1;

  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_ph && !p_rd) begin
        if (exp_ref.size() == 0) begin
          chk(0, "R5", "refresh beyond plan", int'(ref_row), -1);
        end else begin
          int e;
          e = exp_ref.pop_front();
          chk(int'(ref_row) == e, "R5", "refresh row order", int'(ref_row), e);
          chk(int'(wl) == (1 << e), "R4", "word line on refresh", int'(wl), 1 << e);
        end
        if (last_start >= 0 && !acc_seen)
          chk(cyc - last_start == INTERVAL, "R2", "refresh spacing", cyc - last_start, INTERVAL);
        if (ref_row == 0 && last_zero >= 0) begin
          chk(cyc - last_zero == ROWS * INTERVAL, "R5", "pass length",
              cyc - last_zero, ROWS * INTERVAL);
          chk(cyc - last_zero <= HOLD / 2, "R5", "pass within half hold",
              cyc - last_zero, HOLD / 2);
        end
        last_start = cyc;
        acc_seen   = 0;
        if (ref_row == 0) last_zero = cyc;
      end
      if (rd_ph) n_rd++;
      if (amp_ph) n_amp++;
      if (wr_ph) n_wr++;
      if (!rd_ph && p_rd) begin
        chk(n_rd == PH, "R3", "read phase length", n_rd, PH);
        chk(amp_ph, "R3", "amplify follows read", int'(amp_ph), 1);
        n_rd = 0;
      end
      if (!amp_ph && p_amp) begin
        chk(n_amp == PH, "R3", "amplify phase length", n_amp, PH);
        chk(wr_ph, "R3", "rewrite follows amplify", int'(wr_ph), 1);
        n_amp = 0;
      end
      if (!wr_ph && p_wr) begin
        chk(n_wr == PH, "R3", "rewrite phase length", n_wr, PH);
        n_wr = 0;
      end
      if (acc_act && !p_acc) begin
        acc_seen = 1;
        if (exp_acc.size() == 0) begin
          chk(0, "R8", "access not requested", int'(wl), 0);
        end else begin
          int a;
          a = exp_acc.pop_front();
          chk(int'(wl) == (1 << a), "R8", "word line on access", int'(wl), 1 << a);
        end
      end
      if (acc_act) n_acc++;
      if (!acc_act && p_acc) begin
        chk(n_acc == ACC, "R8", "access length", n_acc, ACC);
        n_acc = 0;
      end
      if (!(rd_ph || amp_ph || wr_ph || acc_act))
        chk(wl == '0, "R6", "word lines low when idle", int'(wl), 0);
      p_rd  = rd_ph;
      p_amp = amp_ph;
      p_wr  = wr_ph;
      p_acc = acc_act;
    end
  end

  // driver: user access, expected row pushed for the monitor
  task automatic do_access(input int r);
    exp_acc.push_back(r);
    @(negedge clk);
    acc_req = 1'b1;
    acc_row = ROW_W'(r);
    #1;
    while (!acc_gnt) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  // access request raised in the exact cycle a refresh falls due
  task automatic collide(input int r);
    exp_acc.push_back(r);
    @(posedge rd_ph);
    @(negedge clk);
    repeat (INTERVAL - 1) @(negedge clk);
    acc_req = 1'b1;
    acc_row = ROW_W'(r);
    #1;
    chk(acc_busy == 1'b1, "R7", "busy when refresh due", int'(acc_busy), 1);
    chk(acc_gnt == 1'b0, "R7", "no grant when refresh due", int'(acc_gnt), 0);
    @(negedge clk);
    #1;
    chk(rd_ph == 1'b1, "R7", "refresh wins collision", int'(rd_ph), 1);
    chk(acc_act == 1'b0, "R7", "access held off", int'(acc_act), 0);
    while (!acc_gnt) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R2", "watchdog expired", cyc, 20000);
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    acc_req = 1'b0;
    acc_row = '0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < ROWS; i++) exp_ref.push_back(i);
    exp_ref.push_back(0);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(wl == '0, "R1", "wl in reset", int'(wl), 0);
    chk({rd_ph, amp_ph, wr_ph, acc_act} == 4'b0, "R1", "phases in reset",
        int'({rd_ph, amp_ph, wr_ph, acc_act}), 0);
    chk(ref_row == '0, "R1", "row in reset", int'(ref_row), 0);
    chk(acc_busy == 1'b0 && acc_gnt == 1'b0, "R1", "busy/grant in reset",
        int'({acc_busy, acc_gnt}), 0);
    // R9 configuration flag for good and bad instances
    chk(cfg_err == 1'b0, "R9", "fitting config", int'(cfg_err), 0);
    chk(b_err == 1'b1, "R9", "oversized config", int'(b_err), 1);
    rst_n  = 1'b1;
    mon_on = 1;
    @(negedge clk);
    // R1 just after release
    chk(wl == '0, "R1", "wl after release", int'(wl), 0);
    chk(ref_row == '0, "R1", "row after release", int'(ref_row), 0);
    // R2 idle spacing over the first refreshes
    while (exp_ref.size() > 2 * ROWS + 1 - 3) @(negedge clk);
    // R8 accesses in idle windows
    @(negedge wr_ph);
    do_access(5);
    do_access(15);
    // R7 collision with a due refresh
    collide(9);
    do_access(0);
    // R5 run through the wrap of both passes
    while (exp_ref.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_acc.size() == 0, "R8", "all accesses served", exp_acc.size(), 0);
    finish_run();
  end
endmodule